// File: doc/BRIEF.md
# Attenuated Min-Sum Check Node Unit

This block computes the check-node update for one parity-check row in a min-sum LDPC decoder. It takes one signed variable-to-check message per edge of the row in a single beat. For each edge it returns a check-to-variable message whose magnitude is the smallest input magnitude over the other edges, scaled by a constant attenuation factor. The sign of that message is the parity of the other edges' signs. The block also reports whether the hard decisions of the row's inputs satisfy parity, which a decoder uses to stop iterating early.

The attenuation factor is chosen at run time from seven steps, 1 down to 0.25 in steps of one eighth. It is formed by adding shifted copies of the magnitude, with no multiplier. Input messages are IN_W bits wide. Output messages are MSG_W bits wide, and that width is set independently of IN_W. One output register holds each result. A valid/ready pair at each side moves the data, and a new row is accepted in the same cycle that the previous result leaves.

Top module: `minsum_cnu`

## Requirements
- R1: The input beat is accepted when `inValid` and `inReady` are both 1, where `inReady` is 1 exactly when `outValid` is 0 or `outReady` is 1. An accepted beat sets `outValid` on the next clock edge. `outValid` clears after a cycle with `outReady` 1 in which no new beat is accepted.
- R2: While `outValid` is 1 and `outReady` is 0, `outMsgs` and `paritySat` hold their values.
- R3: Let m1 be the smallest input magnitude and m2 the smallest among the remaining edges. The edge that holds m1 receives m2 and every other edge receives m1. When magnitudes tie, the lowest-numbered edge counts as the holder of m1.
- R4: The sign of edge i's output is the XOR of the sign bits of all inputs except input i. A zero magnitude is always output as 0.
- R5: For `attenSel` value s from 0 to 6, each output magnitude is floor(mag * (8 - s) / 8). The value 7 acts as 6.
- R6: An input equal to the most negative IN_W-bit code is treated as -(2^(IN_W-1) - 1).
- R7: `paritySat` is 1 when an even number of the accepted inputs have their sign bit (the MSB) set, and 0 otherwise.
- R8: Every output lane, read as a signed MSG_W-bit value, lies within ±(2^(IN_W-1) - 1). The most negative MSG_W code is never produced.
- R9: After reset, `outValid` is 0, `outMsgs` is all zeros and `paritySat` is 0.
- R10: Edge i's input occupies bits [i*IN_W +: IN_W] of `inMsgs`, and its output occupies bits [i*MSG_W +: MSG_W] of `outMsgs`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Block can take an input beat |
| inMsgs | input | DEGREE*IN_W | Variable-to-check messages, two's complement, edge 0 in the low bits |
| attenSel | input | 3 | Attenuation select, factor (8 - s)/8 |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Downstream takes the result |
| outMsgs | output | DEGREE*MSG_W | Check-to-variable messages, two's complement |
| paritySat | output | 1 | Hard decisions of the row meet parity |

## Verification
The bench builds the block with DEGREE=6, IN_W=6 and MSG_W=8. With six-bit inputs, random stimulus often produces ties for the minimum and often hits the most negative input code, so the tie rule and the input clamp are exercised without special effort. Making the output two bits wider than the input checks that sign extension and negation are correct when the two widths differ. Six edges are enough that the edge holding the minimum appears at the first, middle and last positions. The bench also stalls `outReady` at random, which exercises both the hold behaviour and acceptance in the same cycle that a result leaves.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch a new row result into the output register
  } cnuStrobe_t;

  localparam int SEL_W = 3;
endpackage

// File: rtl/cnu_atten.sv
module cnu_atten #(
  parameter int MAG_W = 5
) (
  input  logic [MAG_W-1:0]           magIn,
  input  logic [cnu_pkg::SEL_W-1:0]  sel,
  output logic [MAG_W-1:0]           magOut
);
  localparam int SUM_W = MAG_W + 3;

  logic [2:0]       effSel;
  logic [3:0]       weight;
  logic [SUM_W-1:0] ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    effSel = (sel == 3'd7) ? 3'd6 : sel;
    weight = 4'd8 - {1'b0, effSel};
    ext    = SUM_W'(magIn);
    if (weight[3]) begin
      sum = ext << 3;
    end else begin
      sum = (weight[2] ? (ext << 2) : '0)
          + (weight[1] ? (ext << 1) : '0)
          + (weight[0] ? ext : '0);
    end
    magOut = sum[SUM_W-1:3];
  end
endmodule

// File: rtl/cnu_ctrl.sv
module cnu_ctrl
  import cnu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output cnuStrobe_t strobe
);
  always_comb begin
    inReady        = !outValid || outReady;
    strobe.capture = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               outValid <= 1'b0;
    else if (strobe.capture) outValid <= 1'b1;
    else if (outReady)       outValid <= 1'b0;
  end
endmodule

// File: rtl/cnu_datapath.sv
module cnu_datapath
  import cnu_pkg::*;
#(
  parameter int DEGREE = 6,
  parameter int IN_W   = 6,
  parameter int MSG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cnuStrobe_t              strobe,
  input  logic [DEGREE*IN_W-1:0]  inMsgs,
  input  logic [SEL_W-1:0]        attenSel,
  output logic [DEGREE*MSG_W-1:0] outMsgs,
  output logic                    paritySat
);
  localparam int MAG_W = IN_W - 1;
  localparam int IDX_W = (DEGREE > 1) ? $clog2(DEGREE) : 1;
  localparam logic [MAG_W-1:0] MAG_MAX  = {MAG_W{1'b1}};
  localparam logic [IN_W-1:0]  MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [DEGREE-1:0] signBit;
  logic [MAG_W-1:0]  laneMag [DEGREE];
  logic [MAG_W-1:0]  min1, min2, att1, att2;
  logic [IDX_W-1:0]  minIdx;
  logic              signAll;
  logic [DEGREE*MSG_W-1:0] nextMsgs;

  // Per-lane sign and clamped magnitude
  for (genvar gi = 0; gi < DEGREE; gi++) begin : g_mag
    logic [IN_W-1:0] lane, negLane;
    always_comb begin
      lane        = inMsgs[gi*IN_W +: IN_W];
      negLane     = -lane;
      signBit[gi] = lane[IN_W-1];
      if (lane == MOST_NEG)     laneMag[gi] = MAG_MAX;
      else if (lane[IN_W-1])    laneMag[gi] = negLane[MAG_W-1:0];
      else                      laneMag[gi] = lane[MAG_W-1:0];
    end
  end

  // Two-minimum search, lowest index wins ties
  always_comb begin
    min1   = MAG_MAX;
    min2   = MAG_MAX;
    minIdx = '0;
    for (int i = 0; i < DEGREE; i++) begin
      if (laneMag[i] < min1) begin
        min2   = min1;
        min1   = laneMag[i];
        minIdx = IDX_W'(i);
      end else if (laneMag[i] < min2) begin
        min2 = laneMag[i];
      end
    end
    signAll = ^signBit;
  end

  cnu_atten #(.MAG_W(MAG_W)) u_att1 (.magIn(min1), .sel(attenSel), .magOut(att1));
  cnu_atten #(.MAG_W(MAG_W)) u_att2 (.magIn(min2), .sel(attenSel), .magOut(att2));

  // Per-edge message build
  for (genvar go = 0; go < DEGREE; go++) begin : g_out
    logic [MAG_W-1:0] selMag;
    logic [MSG_W-1:0] wideMag;
    always_comb begin
      selMag  = (minIdx == IDX_W'(go)) ? att2 : att1;
      wideMag = MSG_W'(selMag);
      nextMsgs[go*MSG_W +: MSG_W] = (signAll ^ signBit[go]) ? -wideMag : wideMag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outMsgs   <= '0;
      paritySat <= 1'b0;
    end else if (strobe.capture) begin
      outMsgs   <= nextMsgs;
      paritySat <= !signAll;
    end
  end
endmodule

// File: rtl/minsum_cnu.sv
module minsum_cnu #(
  parameter int DEGREE = 6,
  parameter int IN_W   = 6,
  parameter int MSG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [DEGREE*IN_W-1:0]  inMsgs,
  input  logic [2:0]              attenSel,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [DEGREE*MSG_W-1:0] outMsgs,
  output logic                    paritySat
);
  cnu_pkg::cnuStrobe_t strobe;

  cnu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  cnu_datapath #(.DEGREE(DEGREE), .IN_W(IN_W), .MSG_W(MSG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inMsgs(inMsgs),
    .attenSel(attenSel), .outMsgs(outMsgs), .paritySat(paritySat)
  );
endmodule

// File: rtl/cnu_checker.sv
module cnu_checker #(
  parameter int DEGREE = 6,
  parameter int IN_W   = 6,
  parameter int MSG_W  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic                    outValid,
  input logic                    outReady,
  input logic [DEGREE*MSG_W-1:0] outMsgs,
  input logic                    paritySat
);
  localparam int LIMIT = (1 << (IN_W - 1)) - 1;

  // R1: accepted beat yields a result next cycle
  a_r1_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R1: a stalled result blocks input
  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R2: held result does not change
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outMsgs) && $stable(paritySat)));

  // R8: every lane inside the symmetric range
  for (genvar g = 0; g < DEGREE; g++) begin : g_lane
    a_r8_lane_in_range: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> ($signed(outMsgs[g*MSG_W +: MSG_W]) <= LIMIT &&
                    $signed(outMsgs[g*MSG_W +: MSG_W]) >= -LIMIT));
  end
endmodule

bind minsum_cnu cnu_checker #(.DEGREE(DEGREE), .IN_W(IN_W), .MSG_W(MSG_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outMsgs(outMsgs), .paritySat(paritySat)
);

// File: tb/minsum_cnu_tb_top.sv
module minsum_cnu_tb_top;
  localparam int DEG  = 6;
  localparam int IW   = 6;
  localparam int MW   = 8;
  localparam int MAXM = (1 << (IW - 1)) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [DEG*IW-1:0] inMsgs = '0;
  logic [2:0] attenSel = 3'd0;
  logic outValid;
  logic outReady = 1'b0;
  logic [DEG*MW-1:0] outMsgs;
  logic paritySat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  bit modelValid = 1'b0;
  logic [DEG*MW-1:0] modelMsgs = '0;
  bit modelPar = 1'b0;
  string modelTag = "R3";

  always #4 clk = ~clk;

  minsum_cnu #(.DEGREE(DEG), .IN_W(IW), .MSG_W(MW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inMsgs(inMsgs), .attenSel(attenSel), .outValid(outValid),
    .outReady(outReady), .outMsgs(outMsgs), .paritySat(paritySat)
  );

  task automatic check(input string tag, input logic [DEG*MW-1:0] act, input logic [DEG*MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DEG*IW-1:0] mkVec(input int v[DEG]);
    logic [DEG*IW-1:0] r;
    for (int i = 0; i < DEG; i++) r[i*IW +: IW] = IW'(v[i]);
    return r;
  endfunction

  // Behavioural reference from the requirements
  task automatic refCalc(input logic [DEG*IW-1:0] v, input int sel,
                         output logic [DEG*MW-1:0] o, output bit p);
    int mag[DEG];
    bit sb[DEG];
    int sgn, m1, m2, ix, s, a1, a2, val, x;
    sgn = 0;
    for (int i = 0; i < DEG; i++) begin
      x = int'($signed(v[i*IW +: IW]));
      sb[i] = (x < 0);
      if (x < 0) begin sgn ^= 1; x = -x; end
      if (x > MAXM) x = MAXM;
      mag[i] = x;
    end
    m1 = 1 << 30; ix = 0;
    for (int i = 0; i < DEG; i++) if (mag[i] < m1) begin m1 = mag[i]; ix = i; end
    m2 = 1 << 30;
    for (int i = 0; i < DEG; i++) if (i != ix && mag[i] < m2) m2 = mag[i];
    s = (sel > 6) ? 6 : sel;
    a1 = (m1 * (8 - s)) / 8;
    a2 = (m2 * (8 - s)) / 8;
    for (int i = 0; i < DEG; i++) begin
      val = (i == ix) ? a2 : a1;
      if ((sgn ^ int'(sb[i])) != 0) val = -val;
      o[i*MW +: MW] = MW'(val);
    end
    p = (sgn == 0);
  endtask

  task automatic step(input bit iv, input logic [DEG*IW-1:0] d, input int sel,
                      input bit rdy, input string tag);
    logic [DEG*MW-1:0] eo;
    bit ep;
    @(negedge clk);
    check("R1 outValid", {{(DEG*MW-1){1'b0}}, outValid}, {{(DEG*MW-1){1'b0}}, modelValid});
    if (modelValid) begin
      check(modelTag, outMsgs, modelMsgs);
      check("R7 paritySat", {{(DEG*MW-1){1'b0}}, paritySat}, {{(DEG*MW-1){1'b0}}, modelPar});
    end
    inValid = iv; inMsgs = d; attenSel = 3'(sel); outReady = rdy;
    #1;
    check("R1 inReady", {{(DEG*MW-1){1'b0}}, inReady},
          {{(DEG*MW-1){1'b0}}, (!modelValid || rdy)});
    if (modelValid && rdy) modelValid = 1'b0;
    if (iv && inReady) begin
      refCalc(d, sel, eo, ep);
      modelMsgs = eo; modelPar = ep; modelValid = 1'b1; modelTag = tag;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a[DEG];
    logic [DEG*IW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 outValid", {{(DEG*MW-1){1'b0}}, outValid}, '0);
    check("R9 outMsgs", outMsgs, '0);
    check("R9 paritySat", {{(DEG*MW-1){1'b0}}, paritySat}, '0);
    rstN = 1'b1;

    // R3 ties: magnitudes 5,3,7,3,9,10 ; R10 lane order
    a = '{5, -3, 7, 3, 9, -10}; v = mkVec(a);
    step(1, v, 0, 1, "R3 tie");
    a = '{1, 8, 8, 8, 8, 2}; v = mkVec(a);
    step(1, v, 0, 1, "R10 lane order");
    a = '{9, 9, 9, 9, 9, 0}; v = mkVec(a);
    step(1, v, 0, 1, "R4 zero magnitude");
    a = '{-4, -6, -2, 7, -9, -11}; v = mkVec(a);
    step(1, v, 0, 1, "R4 sign");
    // R5 every select value
    a = '{31, -29, 30, 27, -28, 26}; v = mkVec(a);
    for (int s = 0; s < 8; s++) step(1, v, s, 1, "R5 atten");
    // R6 most negative input
    a = '{-32, 20, -17, 25, 22, 30}; v = mkVec(a);
    step(1, v, 0, 1, "R6 clamp");
    // R8 all most negative
    a = '{-32, -32, -32, -32, -32, -31}; v = mkVec(a);
    step(1, v, 0, 1, "R8 range");
    // R2 stall
    a = '{12, -5, 6, 14, -13, 8}; v = mkVec(a);
    step(1, v, 2, 0, "R2 hold");
    for (int k = 0; k < 4; k++) step(1, mkVec('{1, 1, 1, 1, 1, 1}), 0, 0, "R2 hold");
    step(0, '0, 0, 1, "R2 hold");
    step(0, '0, 0, 1, "R1 drain");
    // random traffic with stalls
    for (int n = 0; n < 400; n++) begin
      logic [DEG*IW-1:0] rv;
      rv = {$urandom, $urandom};
      if (($urandom % 4) == 0) rv[($urandom % DEG)*IW +: IW] = {1'b1, {(IW-1){1'b0}}};
      step(($urandom % 4) != 0, rv, int'($urandom % 8), ($urandom % 3) != 0, "R3 random");
    end
    step(0, '0, 0, 1, "R1 drain");
    step(0, '0, 0, 1, "R1 drain");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule